// File: doc/BRIEF.md
# Multi-Speed Data-Strobe Port Repeater

This block is the digital serial front end of a three-port cable node. On the link side, it takes one parallel word per system cycle. It serialises the word at one of three rates and drives it onto every connected port as a data-strobe pair. The data bit goes on the port's `b_out` wire and the strobe on its `a_out` wire. The bit clocks are not separate clocks: a single fast clock runs the block, and each system cycle is eight fast clocks, marked by `sys_tick`. At the slowest rate a bit lasts four fast clocks. At the middle rate it lasts two, and at the fastest rate it lasts one.

When a connected port is selected for reception, the wire roles swap. Data arrives on that port's `a_in` and strobe on its `b_in`. The receiving port's own outputs are silenced. A bit is recovered every time the exclusive-or of data and strobe changes. The recovered bits are packed into words and moved through a small rate-matching FIFO. They are handed to the link side on system-cycle boundaries. At the same time, the registered incoming pair is repeated one clock later onto every other connected port, with data on `b_out` and strobe on `a_out`.

Top module: `ds_port_repeater`

## Requirements
- R1: While `rst` is high at a clock edge, all line outputs, `rx_valid` and `sys_tick` read 0 after that edge.
- R2: `sys_tick` is high for one clock in every eight, first on the eighth clock after reset is released. The edge that ends a high `sys_tick` cycle samples `tx_en`, `tx_bits` and `speed`.
- R3: The `speed` code sets the transmit format. With code 0, the two bits `tx_bits[7:6]` are sent and each lasts 4 clocks. With code 1, the four bits `tx_bits[7:4]` are sent at 2 clocks each. With codes 2 and 3, all eight bits are sent at 1 clock each. Bits go out most significant first, and the first bit appears right after the sampling edge.
- R4: On transmit, the data line (`b_out`) carries the bit value. The strobe line (`a_out`) toggles for a bit only when that bit equals the previous data value, so data XOR strobe changes once per bit.
- R5: If `tx_en` is low at the sampling edge, both transmit lines hold their values for the whole following system cycle.
- R6: A port whose `port_connected` bit is 0 drives 0 on both `a_out` and `b_out`.
- R7: The receiving port is the lowest-index port with both `rx_select` and `port_connected` set. While such a port exists, that port drives 0 on both outputs.
- R8: While receiving, every other connected port drives `b_out` equal to the receiver's `a_in` and `a_out` equal to its `b_in`, each one clock later. Local transmit data does not reach the lines.
- R9: A received bit is the receiver's `a_in` value, taken whenever `a_in ^ b_in` changes. The bits are packed most significant first into words of 2, 4 or 8 bits for the latched speed code (0, 1, 2 or 3), top-aligned with zeros below. Packing starts fresh whenever receive mode begins.
- R10: Received words leave in arrival order. Each one is presented on `rx_bits` with `rx_valid` high, both changing only on the edge that ends a `sys_tick` cycle and holding for eight clocks. `rx_valid` is low for a system cycle with no word waiting. No word is lost at the legal bit rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| speed | input | 2 | Rate code: 0 slowest, 1 middle, 2/3 fastest |
| tx_en | input | 1 | Send the word sampled at this system boundary |
| tx_bits | input | 8 | Transmit word from the link side, top-aligned |
| sys_tick | output | 1 | Marks the last fast clock of each system cycle |
| port_connected | input | 3 | Per-port connected flag |
| rx_select | input | 3 | Per-port request to receive |
| a_in | input | 3 | Per-port A wire in (data when receiving) |
| b_in | input | 3 | Per-port B wire in (strobe when receiving) |
| a_out | output | 3 | Per-port A wire out (strobe when transmitting) |
| b_out | output | 3 | Per-port B wire out (data when transmitting) |
| rx_bits | output | 8 | Received word, top-aligned |
| rx_valid | output | 1 | `rx_bits` holds a new word for this system cycle |

## Verification
The FIFO assertions assume the far end never sends faster than one word per system cycle. They also assume that each incoming bit holds for at least one clock at the latched speed. The receive checks further take it that `speed` stays constant while a port is receiving and that the selected pair is idle at 0 when receive mode starts. The stimulus respects these limits. It holds every sent bit for exactly the bit period of the current speed and changes `speed` only outside receive windows, waiting two system cycles before a new window opens. It also returns all receive wires to 0 before deselecting a port.

// File: rtl/ds_pkg.sv
package ds_pkg;

    localparam int unsigned DS_WORD_W = 8;
    localparam int unsigned DS_PORTS  = 3;

    typedef enum logic [1:0] {
        SPD_S100 = 2'd0,
        SPD_S200 = 2'd1,
        SPD_S400 = 2'd2,
        SPD_RSVD = 2'd3
    } ds_speed_e;

    typedef struct packed {
        logic data;
        logic strobe;
    } ds_pair_t;

    // fast clocks per bit for a speed code
    function automatic int unsigned ds_period(input ds_speed_e s);
        case (s)
            SPD_S100: return 4;
            SPD_S200: return 2;
            default:  return 1;
        endcase
    endfunction

    // bits carried in one system cycle of word_w fast clocks
    function automatic int unsigned ds_word_bits(input ds_speed_e s, input int unsigned word_w);
        return word_w / ds_period(s);
    endfunction

    function automatic logic ds_is_bit_edge(input int unsigned phase, input int unsigned period);
        if (period == 0) return 1'b0;
        return (phase % period) == (period - 1);
    endfunction

endpackage

// File: rtl/ds_phase_gen.sv
module ds_phase_gen #(
    parameter  int unsigned PHASES = 8,
    localparam int unsigned PH_W   = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            tick
);

    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    always_ff @(posedge clk) begin
        if (rst)               phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);

    // system cycle restarts right after every tick
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (phase == '0));

endmodule

// File: rtl/ds_tx_serializer.sv
module ds_tx_serializer
    import ds_pkg::*;
#(
    parameter  int unsigned WORD_W = 8,
    localparam int unsigned PH_W   = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   phase,
    input  logic              tick,
    input  ds_speed_e         speed_in,
    input  logic              tx_en,
    input  logic [WORD_W-1:0] tx_word,
    output ds_speed_e         speed_q,
    output ds_pair_t          enc_q
);

    logic [WORD_W-1:0] sh_q;
    logic              act_q;
    int unsigned       per;
    logic              bit_edge;
    logic              fire;
    logic              nxt_bit;

    always_comb begin
        per      = ds_period(tick ? speed_in : speed_q);
        bit_edge = ds_is_bit_edge(32'(phase), per);
        fire     = bit_edge && (tick ? tx_en : act_q);
        nxt_bit  = tick ? tx_word[WORD_W-1] : sh_q[WORD_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            act_q   <= 1'b0;
            speed_q <= SPD_S100;
            enc_q   <= '0;
        end else begin
            if (tick) begin
                speed_q <= speed_in;
                act_q   <= tx_en;
                sh_q    <= tx_word << 1;
            end else if (bit_edge) begin
                sh_q    <= sh_q << 1;
            end
            if (fire) begin
                enc_q.data   <= nxt_bit;
                enc_q.strobe <= (nxt_bit == enc_q.data) ? ~enc_q.strobe : enc_q.strobe;
            end
        end
    end

    assert_ds_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        fire |=> ((enc_q.data ^ enc_q.strobe) != $past(enc_q.data ^ enc_q.strobe)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(enc_q));

endmodule

// File: rtl/ds_rx_recover.sv
module ds_rx_recover
    import ds_pkg::*;
#(
    parameter  int unsigned WORD_W = 8,
    localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_on,
    input  ds_pair_t          pair_in,
    input  ds_speed_e         speed,
    output ds_pair_t          pair_q,
    output logic              push,
    output logic [WORD_W-1:0] word
);

    logic              x_prev_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] acc_q;
    logic              x_now;
    logic              bit_ev;
    logic              last;
    int unsigned       nbits;
    logic [WORD_W-1:0] acc_nx;

    always_comb begin
        x_now  = pair_q.data ^ pair_q.strobe;
        bit_ev = rx_on && (x_now != x_prev_q);
        nbits  = ds_word_bits(speed, WORD_W);
        acc_nx = {acc_q[WORD_W-2:0], pair_q.data};
        last   = (32'(cnt_q) + 1) == nbits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q   <= '0;
            x_prev_q <= 1'b0;
            cnt_q    <= '0;
            acc_q    <= '0;
            push     <= 1'b0;
            word     <= '0;
        end else begin
            pair_q   <= pair_in;
            x_prev_q <= x_now;
            push     <= 1'b0;
            if (!rx_on) begin
                cnt_q <= '0;
                acc_q <= '0;
            end else if (bit_ev) begin
                if (last) begin
                    push  <= 1'b1;
                    word  <= acc_nx << (WORD_W - nbits);
                    cnt_q <= '0;
                    acc_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    acc_q <= acc_nx;
                end
            end
        end
    end

endmodule

// File: rtl/ds_rate_fifo.sv
module ds_rate_fifo #(
    parameter  int unsigned W     = 8,
    parameter  int unsigned DEPTH = 4,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         tick,
    output logic [W-1:0] rdata_q,
    output logic         valid_q
);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] count_q;
    logic          accept, pop;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign accept = push && (count_q < CW'(DEPTH));
    assign pop    = tick && (count_q != '0);

    always_ff @(posedge clk) begin
        if (accept) mem_q[wr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
            valid_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) wr_q <= wrap_inc(wr_q);
            if (tick) begin
                valid_q <= pop;
                if (pop) begin
                    rdata_q <= mem_q[rd_q];
                    rd_q    <= wrap_inc(rd_q);
                end
            end
            count_q <= count_q + CW'(accept) - CW'(pop);
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        push |-> (count_q < CW'(DEPTH)));

    assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(valid_q) && $stable(rdata_q)));

endmodule

// File: rtl/ds_port_repeater.sv
module ds_port_repeater
    import ds_pkg::*;
#(
    parameter int unsigned NUM_PORTS  = DS_PORTS,
    parameter int unsigned WORD_W     = DS_WORD_W,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           speed,
    input  logic                 tx_en,
    input  logic [WORD_W-1:0]    tx_bits,
    output logic                 sys_tick,
    input  logic [NUM_PORTS-1:0] port_connected,
    input  logic [NUM_PORTS-1:0] rx_select,
    input  logic [NUM_PORTS-1:0] a_in,
    input  logic [NUM_PORTS-1:0] b_in,
    output logic [NUM_PORTS-1:0] a_out,
    output logic [NUM_PORTS-1:0] b_out,
    output logic [WORD_W-1:0]    rx_bits,
    output logic                 rx_valid
);

    localparam int unsigned PH_W = $clog2(WORD_W);

    logic [PH_W-1:0]      phase;
    ds_speed_e            speed_q;
    ds_pair_t             tx_line;
    ds_pair_t             pair_in;
    ds_pair_t             rep;
    logic [NUM_PORTS-1:0] cand, rx_mask;
    logic                 rx_on;
    logic                 rx_push;
    logic [WORD_W-1:0]    rx_word;

    ds_phase_gen #(.PHASES(WORD_W)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .tick  (sys_tick)
    );

    ds_tx_serializer #(.WORD_W(WORD_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .tick     (sys_tick),
        .speed_in (ds_speed_e'(speed)),
        .tx_en    (tx_en),
        .tx_word  (tx_bits),
        .speed_q  (speed_q),
        .enc_q    (tx_line)
    );

    // lowest-index connected port that asks to receive
    always_comb begin
        cand    = rx_select & port_connected;
        rx_mask = cand & (~cand + NUM_PORTS'(1));
        rx_on   = |cand;
        pair_in = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rx_mask[p]) begin
                pair_in.data   = a_in[p];
                pair_in.strobe = b_in[p];
            end
        end
    end

    ds_rx_recover #(.WORD_W(WORD_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .rx_on   (rx_on),
        .pair_in (pair_in),
        .speed   (speed_q),
        .pair_q  (rep),
        .push    (rx_push),
        .word    (rx_word)
    );

    ds_rate_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (rx_push),
        .wdata   (rx_word),
        .tick    (sys_tick),
        .rdata_q (rx_bits),
        .valid_q (rx_valid)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign b_out[g] = !port_connected[g] ? 1'b0 :
                          rx_on ? (rx_mask[g] ? 1'b0 : rep.data)   : tx_line.data;
        assign a_out[g] = !port_connected[g] ? 1'b0 :
                          rx_on ? (rx_mask[g] ? 1'b0 : rep.strobe) : tx_line.strobe;

        assert_repeat_follows_R8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && rx_on && $past(rx_on) && $stable(rx_mask)
             && port_connected[g] && !rx_mask[g])
            |-> (b_out[g] == $past(pair_in.data) && a_out[g] == $past(pair_in.strobe)));
    end

endmodule

// File: tb/ds_port_repeater_tb.sv
module ds_port_repeater_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] speed;
    logic       tx_en;
    logic [7:0] tx_bits;
    logic       sys_tick;
    logic [2:0] port_connected, rx_select, a_in, b_in, a_out, b_out;
    logic [7:0] rx_bits;
    logic       rx_valid;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    // behavioural reference state
    int  m_ph;
    int  m_spd;
    bit  m_act, m_d, m_s, rep_d, rep_s;
    int  txq[$];
    int  expq[$];

    always #10 clk = ~clk;

    ds_port_repeater u_dut (
        .clk(clk), .rst(rst), .speed(speed), .tx_en(tx_en), .tx_bits(tx_bits),
        .sys_tick(sys_tick), .port_connected(port_connected), .rx_select(rx_select),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
        .rx_bits(rx_bits), .rx_valid(rx_valid)
    );

    function automatic int per_of(int s);
        return (s == 0) ? 4 : (s == 1) ? 2 : 1;
    endfunction

    function automatic int nb_of(int s);
        return 8 / per_of(s);
    endfunction

    function automatic int sel_port();
        for (int p = 0; p < 3; p++)
            if (rx_select[p] && port_connected[p]) return p;
        return -1;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int sp, pr, ea, eb, w;
        bit b;
        string tag;
        if (rst) begin
            m_ph = 0; m_spd = 0; m_act = 0; m_d = 0; m_s = 0; rep_d = 0; rep_s = 0;
            txq.delete();
        end else begin
            sp = sel_port();
            rep_d = (sp >= 0) ? a_in[sp] : 1'b0;
            rep_s = (sp >= 0) ? b_in[sp] : 1'b0;
            pr = per_of((m_ph == 7) ? int'(speed) : m_spd);
            if (m_ph == 7) begin
                m_spd = speed;
                m_act = tx_en;
                txq.delete();
                if (tx_en)
                    for (int k = 0; k < nb_of(m_spd); k++) txq.push_back(tx_bits[7-k]);
            end
            if ((m_ph % pr) == pr - 1 && m_act && txq.size() > 0) begin
                b = txq.pop_front();
                if (b == m_d) m_s = !m_s;
                m_d = b;
            end
            m_ph = (m_ph + 1) % 8;
        end
        #5;
        if (rst) begin
            chk("R1", "reset a_out", a_out, 0);
            chk("R1", "reset b_out", b_out, 0);
            chk("R1", "reset rx_valid", rx_valid, 0);
            chk("R1", "reset sys_tick", sys_tick, 0);
        end else begin
            chk("R2", "sys_tick", sys_tick, (m_ph == 7));
            sp = sel_port();
            for (int p = 0; p < 3; p++) begin
                if (!port_connected[p])  begin ea = 0;     eb = 0;     tag = "R6"; end
                else if (sp == p)        begin ea = 0;     eb = 0;     tag = "R7"; end
                else if (sp >= 0)        begin ea = rep_s; eb = rep_d; tag = "R8"; end
                else                     begin ea = m_s;   eb = m_d;   tag = "R3 R4 R5"; end
                chk(tag, $sformatf("a_out[%0d]", p), a_out[p], ea);
                chk(tag, $sformatf("b_out[%0d]", p), b_out[p], eb);
            end
            if (m_ph == 0 && rx_valid) begin
                if (expq.size() == 0) chk("R10", "unexpected rx_valid", 1, 0);
                else begin
                    w = expq.pop_front();
                    chk("R9", "rx_bits", rx_bits, w);
                end
            end
        end
    end

    task automatic tx_run(int spd, int nwords);
        speed = 2'(spd);
        for (int w = 0; w < nwords; w++) begin
            tx_bits = (w == 0) ? 8'hFF : (w == 1) ? 8'h00 : (w == 2) ? 8'hA5 : 8'($urandom);
            tx_en   = (w % 4 != 3);
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic send_words(int port, int spd, int nwords);
        int word, n, msk;
        bit b;
        n = nb_of(spd);
        msk = ((1 << n) - 1) << (8 - n);
        for (int w = 0; w < nwords; w++) begin
            word = (w == 0) ? msk : (w == 1) ? 0 : (int'($urandom) & msk);
            expq.push_back(word);
            for (int k = 0; k < n; k++) begin
                b = word[7-k];
                if (b == a_in[port]) b_in[port] = !b_in[port];
                a_in[port] = b;
                repeat (per_of(spd)) @(negedge clk);
            end
        end
    endtask

    task automatic rx_test(int spd, logic [2:0] conn, logic [2:0] sel, int port, int nwords);
        speed = 2'(spd);
        port_connected = conn;
        repeat (16) @(negedge clk);
        rx_select = sel;
        repeat (3) @(negedge clk);
        send_words(port, spd, nwords);
        repeat (48) @(negedge clk);
        rx_select = 3'b000;
        a_in = 3'b000;
        b_in = 3'b000;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; speed = 2'd0; tx_en = 1'b0; tx_bits = 8'h00;
        port_connected = 3'b111; rx_select = 3'b000; a_in = 3'b000; b_in = 3'b000;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < 4; s++) tx_run(s, 10);
        port_connected = 3'b101;
        tx_run(2, 6);
        port_connected = 3'b110;
        rx_select = 3'b001;
        tx_run(1, 4);
        rx_select = 3'b000;
        port_connected = 3'b111;
        rx_test(1, 3'b111, 3'b010, 1, 6);
        rx_test(0, 3'b111, 3'b110, 1, 5);
        rx_test(2, 3'b101, 3'b100, 2, 6);
        rx_test(3, 3'b111, 3'b001, 0, 4);
        tx_run(0, 3);
        chk("R10", "undelivered words", expq.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule